// File: doc/BRIEF.md
# Nested Interrupt Acknowledge and Completion Tracker

This block sits beside the priority selector of a multi-CPU interrupt controller and owns the acknowledge and completion handshake for each CPU. When a CPU acknowledges, the block takes the highest-pending ID that the selector presents for that CPU. If that interrupt beats the running priority, the block makes it the running interrupt and remembers which interrupt it pre-empted. It also emits a strobe telling the pending-state owner which pending bits to clear. In every other case it answers with the spurious ID 1023.

When a CPU writes an end-of-interrupt, the block unwinds its nesting state. Each CPU keeps a linked list of "previously running" IDs in a per-CPU table indexed by interrupt ID. Completing the running interrupt pops that list. Completing an interrupt deeper in the nest splices it out of the list, using a small walker that follows one link per cycle and holds `busy` while it runs. On completion, a level-sensitive source whose input is still high is handed back as pending for that CPU.

Top module: `nest_ack_tracker`

## Requirements
- R1: After reset every CPU's running ID is 1023 and its running priority is 256 (bit PRIO_W set). `busy`, `ackValid`, `pendClrValid` and `pendSetValid` are low.
- R2: An acknowledge gives `ackValid` with `ackId` 1023 one cycle later, and nothing changes, in three cases: the highest-pending ID is 1023, the ID is not below NUM_SRC, or the ID's priority is not strictly lower than that CPU's running priority. An equal priority is refused.
- R3: A successful acknowledge gives `ackValid` with `ackId` equal to the pending ID one cycle later. In the same cycle the CPU's running ID becomes that ID and its running priority becomes that source's priority.
- R4: A successful acknowledge pulses `pendClrValid` for one cycle with `pendClrId` set to the ID. `pendClrMask` is the one-hot bit of the acknowledging CPU when `srcAllCpu` is 0 for that source, and all ones when it is 1.
- R5: An end-of-interrupt on a CPU whose running ID is 1023 has no effect: running state is unchanged and no re-pend strobe is issued.
- R6: The completed ID is bits [9:0] of `eoiData`. Bits above bit 9 are ignored.
- R7: Completing the running ID makes its stored predecessor the running ID. The running priority becomes that predecessor's priority, or 256 when the predecessor is 1023.
- R8: A completion pulses `pendSetValid` with `pendSetId` = ID and a one-hot `pendSetMask` for the completing CPU. This happens only when the source is enabled, level-sensitive (`srcEdge` 0) and has its input high, and its `srcTarget` bit for that CPU (bit ID*NUM_CPU+cpu) is set.
- R9: Completing a non-running ID starts a walk from the running ID. The walk follows one predecessor link per cycle and holds `busy` high. It ends at a link equal to 1023, or at the link that equals the completed ID; that link is replaced by the completed ID's own predecessor. Running IDs do not change during the walk.
- R10: While `busy` is high, acknowledge and end-of-interrupt requests are dropped: no `ackValid` and no state change.
- R11: Each CPU's running ID, priority and predecessor table are independent of the other CPUs' traffic.
- R12: When acknowledge and end-of-interrupt requests arrive in the same cycle, the acknowledge is served and the end-of-interrupt is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ackReq | input | 1 | Acknowledge request strobe |
| ackCpu | input | CPU_W | CPU issuing the acknowledge |
| hiPendId | input | NUM_CPU*10 | Highest-pending ID per CPU from the selector |
| ackValid | output | 1 | Acknowledge answer valid |
| ackId | output | 10 | Acknowledged ID or 1023 |
| eoiReq | input | 1 | End-of-interrupt strobe |
| eoiCpu | input | CPU_W | CPU issuing the completion |
| eoiData | input | 32 | Written completion value |
| srcPrio | input | NUM_SRC*PRIO_W | Per-source priority |
| srcEnable | input | NUM_SRC | Per-source enable |
| srcLevel | input | NUM_SRC | Per-source input level |
| srcEdge | input | NUM_SRC | 1 = edge-sensitive source |
| srcAllCpu | input | NUM_SRC | 1 = acknowledge clears pending on all CPUs |
| srcTarget | input | NUM_SRC*NUM_CPU | Per-source CPU target bits |
| pendClrValid | output | 1 | Pending clear strobe |
| pendClrId | output | 10 | ID to clear |
| pendClrMask | output | NUM_CPU | CPUs to clear |
| pendSetValid | output | 1 | Re-pend strobe |
| pendSetId | output | 10 | ID to set pending |
| pendSetMask | output | NUM_CPU | CPU to set pending |
| runIdFlat | output | NUM_CPU*10 | Running ID per CPU |
| runPrioFlat | output | NUM_CPU*(PRIO_W+1) | Running priority per CPU |
| busy | output | 1 | Chain walk in progress |

## Verification
The hardest case to reach from the ports is a completion that arrives out of order inside a nest at least three deep. Reaching it takes several acknowledges with strictly falling priorities, followed by an end-of-interrupt naming the oldest interrupt. That ID is neither running nor the running ID's direct predecessor, so the walker must step past one link before it splices. The stimulus builds such a three-deep nest on one CPU and completes its bottom entry with junk in the upper bits of the written value. It then pops the remaining two entries, showing that the splice took effect. A request is also injected mid-walk to show it is dropped.

// File: rtl/nat_pkg.sv
package nat_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_ID = 10'd1023;

  typedef enum logic {ST_IDLE, ST_WALK} walkState_e;

  typedef struct packed {
    logic ackTake;
    logic ackRefuse;
    logic eoiPop;
    logic repend;
    logic walkStart;
    logic walkStep;
    logic walkSplice;
  } ctlStrobe_t;
endpackage

// File: rtl/nat_ctrl.sv
module nat_ctrl
  import nat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackReq,
  input  logic       eoiReq,
  input  logic       canAck,
  input  logic       runIdle,
  input  logic       eoiIsRun,
  input  logic       eoiRepend,
  input  logic       linkEnd,
  input  logic       linkHit,
  input  logic       walkExpired,
  output ctlStrobe_t ctl,
  output logic       busy
);
  walkState_e state;
  logic idle;
  logic eoiGo;

  always_comb begin
    idle  = (state == ST_IDLE);
    // acknowledge wins a same-cycle collision; completion on an idle CPU is void
    eoiGo = idle && eoiReq && !ackReq && !runIdle;
    ctl   = '0;
    ctl.ackTake    = idle && ackReq && canAck;
    ctl.ackRefuse  = idle && ackReq && !canAck;
    ctl.repend     = eoiGo && eoiRepend;
    ctl.eoiPop     = eoiGo && eoiIsRun;
    ctl.walkStart  = eoiGo && !eoiIsRun;
    ctl.walkSplice = !idle && !linkEnd && linkHit;
    ctl.walkStep   = !idle && !linkEnd && !linkHit && !walkExpired;
    busy = !idle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (ctl.walkStart) state <= ST_WALK;
        ST_WALK: if (!ctl.walkStep) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nat_dpath.sv
module nat_dpath
  import nat_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int RP_W   = PRIO_W + 1
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 ctl,
  input  logic [CPU_W-1:0]           ackCpu,
  input  logic [NUM_CPU*ID_W-1:0]    hiPendId,
  input  logic [CPU_W-1:0]           eoiCpu,
  input  logic [31:0]                eoiData,
  input  logic [NUM_SRC*PRIO_W-1:0]  srcPrio,
  input  logic [NUM_SRC-1:0]         srcEnable,
  input  logic [NUM_SRC-1:0]         srcLevel,
  input  logic [NUM_SRC-1:0]         srcEdge,
  input  logic [NUM_SRC-1:0]         srcAllCpu,
  input  logic [NUM_SRC*NUM_CPU-1:0] srcTarget,
  output logic                       canAck,
  output logic                       runIdle,
  output logic                       eoiIsRun,
  output logic                       eoiRepend,
  output logic                       linkEnd,
  output logic                       linkHit,
  output logic                       walkExpired,
  output logic                       ackValid,
  output logic [ID_W-1:0]            ackId,
  output logic                       pendClrValid,
  output logic [ID_W-1:0]            pendClrId,
  output logic [NUM_CPU-1:0]         pendClrMask,
  output logic                       pendSetValid,
  output logic [ID_W-1:0]            pendSetId,
  output logic [NUM_CPU-1:0]         pendSetMask,
  output logic [NUM_CPU*ID_W-1:0]    runIdFlat,
  output logic [NUM_CPU*RP_W-1:0]    runPrioFlat
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CNT_W = $clog2(NUM_SRC + 1);
  localparam logic [RP_W-1:0] RP_IDLE = RP_W'(1) << PRIO_W;

  logic [ID_W-1:0]  runId   [NUM_CPU];
  logic [RP_W-1:0]  runPrio [NUM_CPU];
  logic [ID_W-1:0]  predTab [NUM_CPU][NUM_SRC];

  logic [CPU_W-1:0] walkCpu;
  logic [ID_W-1:0]  walkId;
  logic [ID_W-1:0]  cursor;
  logic [CNT_W-1:0] walkCnt;

  logic [ID_W-1:0]  hpId, eoiId, popId, link, spliceVal;
  logic [IDX_W-1:0] hpIdx, eoiIdx;
  logic [RP_W-1:0]  hpPrio, popPrio;

  always_comb begin
    hpId    = hiPendId[int'(ackCpu)*ID_W +: ID_W];
    hpIdx   = hpId[IDX_W-1:0];
    hpPrio  = {1'b0, srcPrio[int'(hpIdx)*PRIO_W +: PRIO_W]};
    canAck  = (hpId < ID_W'(NUM_SRC)) && (hpPrio < runPrio[ackCpu]);

    eoiId     = eoiData[ID_W-1:0];
    eoiIdx    = eoiId[IDX_W-1:0];
    runIdle   = (runId[eoiCpu] == NO_ID);
    eoiIsRun  = (eoiId == runId[eoiCpu]);
    eoiRepend = (eoiId < ID_W'(NUM_SRC)) && !srcEdge[eoiIdx] && srcEnable[eoiIdx]
                && srcLevel[eoiIdx] && srcTarget[int'(eoiIdx)*NUM_CPU + int'(eoiCpu)];

    popId   = predTab[eoiCpu][runId[eoiCpu][IDX_W-1:0]];
    popPrio = (popId == NO_ID) ? RP_IDLE
            : {1'b0, srcPrio[int'(popId[IDX_W-1:0])*PRIO_W +: PRIO_W]};

    link        = predTab[walkCpu][cursor[IDX_W-1:0]];
    spliceVal   = predTab[walkCpu][walkId[IDX_W-1:0]];
    linkEnd     = (link == NO_ID);
    linkHit     = (link == walkId);
    walkExpired = (walkCnt == CNT_W'(NUM_SRC - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        runId[c]   <= NO_ID;
        runPrio[c] <= RP_IDLE;
        for (int s = 0; s < NUM_SRC; s++) predTab[c][s] <= NO_ID;
      end
      walkCpu      <= '0;
      walkId       <= NO_ID;
      cursor       <= NO_ID;
      walkCnt      <= '0;
      ackValid     <= 1'b0;
      ackId        <= NO_ID;
      pendClrValid <= 1'b0;
      pendClrId    <= NO_ID;
      pendClrMask  <= '0;
      pendSetValid <= 1'b0;
      pendSetId    <= NO_ID;
      pendSetMask  <= '0;
    end else begin
      ackValid     <= 1'b0;
      pendClrValid <= 1'b0;
      pendSetValid <= 1'b0;
      if (ctl.ackTake) begin
        predTab[ackCpu][hpIdx] <= runId[ackCpu];
        runId[ackCpu]   <= hpId;
        runPrio[ackCpu] <= hpPrio;
        ackValid        <= 1'b1;
        ackId           <= hpId;
        pendClrValid    <= 1'b1;
        pendClrId       <= hpId;
        pendClrMask     <= srcAllCpu[hpIdx] ? '1 : (NUM_CPU'(1) << ackCpu);
      end
      if (ctl.ackRefuse) begin
        ackValid <= 1'b1;
        ackId    <= NO_ID;
      end
      if (ctl.repend) begin
        pendSetValid <= 1'b1;
        pendSetId    <= eoiId;
        pendSetMask  <= NUM_CPU'(1) << eoiCpu;
      end
      if (ctl.eoiPop) begin
        runId[eoiCpu]   <= popId;
        runPrio[eoiCpu] <= popPrio;
      end
      if (ctl.walkStart) begin
        walkCpu <= eoiCpu;
        walkId  <= eoiId;
        cursor  <= runId[eoiCpu];
        walkCnt <= '0;
      end
      if (ctl.walkStep) begin
        cursor  <= link;
        walkCnt <= walkCnt + 1'b1;
      end
      if (ctl.walkSplice) predTab[walkCpu][cursor[IDX_W-1:0]] <= spliceVal;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_flat
    assign runIdFlat[c*ID_W +: ID_W]   = runId[c];
    assign runPrioFlat[c*RP_W +: RP_W] = runPrio[c];
  end
endmodule

// File: rtl/nest_ack_tracker.sv
module nest_ack_tracker
  import nat_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int RP_W   = PRIO_W + 1
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ackReq,
  input  logic [CPU_W-1:0]           ackCpu,
  input  logic [NUM_CPU*ID_W-1:0]    hiPendId,
  output logic                       ackValid,
  output logic [ID_W-1:0]            ackId,
  input  logic                       eoiReq,
  input  logic [CPU_W-1:0]           eoiCpu,
  input  logic [31:0]                eoiData,
  input  logic [NUM_SRC*PRIO_W-1:0]  srcPrio,
  input  logic [NUM_SRC-1:0]         srcEnable,
  input  logic [NUM_SRC-1:0]         srcLevel,
  input  logic [NUM_SRC-1:0]         srcEdge,
  input  logic [NUM_SRC-1:0]         srcAllCpu,
  input  logic [NUM_SRC*NUM_CPU-1:0] srcTarget,
  output logic                       pendClrValid,
  output logic [ID_W-1:0]            pendClrId,
  output logic [NUM_CPU-1:0]         pendClrMask,
  output logic                       pendSetValid,
  output logic [ID_W-1:0]            pendSetId,
  output logic [NUM_CPU-1:0]         pendSetMask,
  output logic [NUM_CPU*ID_W-1:0]    runIdFlat,
  output logic [NUM_CPU*RP_W-1:0]    runPrioFlat,
  output logic                       busy
);
  ctlStrobe_t ctl;
  logic canAck, runIdle, eoiIsRun, eoiRepend, linkEnd, linkHit, walkExpired;

  nat_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ackReq(ackReq), .eoiReq(eoiReq),
    .canAck(canAck), .runIdle(runIdle), .eoiIsRun(eoiIsRun), .eoiRepend(eoiRepend),
    .linkEnd(linkEnd), .linkHit(linkHit), .walkExpired(walkExpired),
    .ctl(ctl), .busy(busy)
  );

  nat_dpath #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ackCpu(ackCpu), .hiPendId(hiPendId),
    .eoiCpu(eoiCpu), .eoiData(eoiData), .srcPrio(srcPrio), .srcEnable(srcEnable),
    .srcLevel(srcLevel), .srcEdge(srcEdge), .srcAllCpu(srcAllCpu), .srcTarget(srcTarget),
    .canAck(canAck), .runIdle(runIdle), .eoiIsRun(eoiIsRun), .eoiRepend(eoiRepend),
    .linkEnd(linkEnd), .linkHit(linkHit), .walkExpired(walkExpired),
    .ackValid(ackValid), .ackId(ackId),
    .pendClrValid(pendClrValid), .pendClrId(pendClrId), .pendClrMask(pendClrMask),
    .pendSetValid(pendSetValid), .pendSetId(pendSetId), .pendSetMask(pendSetMask),
    .runIdFlat(runIdFlat), .runPrioFlat(runPrioFlat)
  );
endmodule

// File: rtl/nest_ack_tracker_chk.sv
module nest_ack_tracker_chk
  import nat_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int PRIO_W  = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int RP_W   = PRIO_W + 1
)(
  input logic                    clk,
  input logic                    rstN,
  input logic                    ackReq,
  input logic [CPU_W-1:0]        ackCpu,
  input logic                    busy,
  input logic                    ackValid,
  input logic [ID_W-1:0]         ackId,
  input logic [NUM_CPU*ID_W-1:0] runIdFlat,
  input logic [NUM_CPU*RP_W-1:0] runPrioFlat,
  input logic                    pendClrValid,
  input logic [NUM_CPU-1:0]      pendClrMask,
  input logic                    pendSetValid,
  input logic [NUM_CPU-1:0]      pendSetMask
);
  logic [CPU_W-1:0] reqCpuQ;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) reqCpuQ <= '0;
    else       reqCpuQ <= ackCpu;

  assert_ack_sets_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && ackId != NO_ID |-> runIdFlat[int'(reqCpuQ)*ID_W +: ID_W] == ackId);

  assert_refuse_keeps_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && ackId == NO_ID |-> $stable(runIdFlat));

  assert_clr_mask_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    pendClrValid |-> pendClrMask != '0);

  assert_repend_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    pendSetValid |-> $onehot(pendSetMask));

  assert_walk_freezes_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(runIdFlat));

  assert_drop_when_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy && ackReq |=> !ackValid);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assert_idle_prio_R7: assert property (@(posedge clk) disable iff (!rstN)
      runIdFlat[c*ID_W +: ID_W] == NO_ID |-> runPrioFlat[c*RP_W +: RP_W] == (RP_W'(1) << PRIO_W));
  end
endmodule

bind nest_ack_tracker nest_ack_tracker_chk #(.NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) chk_i (
  .clk(clk), .rstN(rstN), .ackReq(ackReq), .ackCpu(ackCpu), .busy(busy),
  .ackValid(ackValid), .ackId(ackId), .runIdFlat(runIdFlat), .runPrioFlat(runPrioFlat),
  .pendClrValid(pendClrValid), .pendClrMask(pendClrMask),
  .pendSetValid(pendSetValid), .pendSetMask(pendSetMask)
);

// File: tb/nest_ack_tracker_tb_top.sv
`timescale 1ns/1ps
module nest_ack_tracker_tb_top;
  localparam int NC = 2;
  localparam int NS = 32;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ackReq = 1'b0, eoiReq = 1'b0;
  logic [0:0] ackCpu = '0, eoiCpu = '0;
  logic [NC*10-1:0] hiPendId = '1;
  logic [31:0] eoiData = '0;
  logic [NS*PW-1:0] srcPrio;
  logic [NS-1:0] srcEnable = '0, srcLevel = '0, srcEdge = '0, srcAllCpu = '0;
  logic [NS*NC-1:0] srcTarget = '0;
  logic ackValid, pendClrValid, pendSetValid, busy;
  logic [9:0] ackId, pendClrId, pendSetId;
  logic [NC-1:0] pendClrMask, pendSetMask;
  logic [NC*10-1:0] runIdFlat;
  logic [NC*9-1:0] runPrioFlat;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [9:0] expQ[$];

  always #2.5 clk = ~clk;

  nest_ack_tracker #(.NUM_CPU(NC), .NUM_SRC(NS), .PRIO_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .ackReq(ackReq), .ackCpu(ackCpu), .hiPendId(hiPendId),
    .ackValid(ackValid), .ackId(ackId), .eoiReq(eoiReq), .eoiCpu(eoiCpu), .eoiData(eoiData),
    .srcPrio(srcPrio), .srcEnable(srcEnable), .srcLevel(srcLevel), .srcEdge(srcEdge),
    .srcAllCpu(srcAllCpu), .srcTarget(srcTarget),
    .pendClrValid(pendClrValid), .pendClrId(pendClrId), .pendClrMask(pendClrMask),
    .pendSetValid(pendSetValid), .pendSetId(pendSetId), .pendSetMask(pendSetMask),
    .runIdFlat(runIdFlat), .runPrioFlat(runPrioFlat), .busy(busy)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] rid(int c);
    return runIdFlat[c*10 +: 10];
  endfunction
  function automatic logic [8:0] rpr(int c);
    return runPrioFlat[c*9 +: 9];
  endfunction

  // monitor: every acknowledge answer is compared with the scoreboard
  always @(negedge clk) begin
    if (rstN && ackValid) begin
      if (expQ.size() == 0) check("R10 unexpected ack", {22'd0, ackId}, 32'h3ff_dead);
      else check("R3 ack id", {22'd0, ackId}, {22'd0, expQ.pop_front()});
    end
  end

  task automatic doAck(int cpu, logic [9:0] hp, logic [9:0] exp);
    @(negedge clk);
    ackCpu = cpu[0:0];
    hiPendId[cpu*10 +: 10] = hp;
    ackReq = 1'b1;
    expQ.push_back(exp);
    @(posedge clk);
    @(negedge clk);
    ackReq = 1'b0;
  endtask

  task automatic doEoi(int cpu, logic [31:0] data);
    @(negedge clk);
    eoiCpu = cpu[0:0];
    eoiData = data;
    eoiReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eoiReq = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) srcPrio[s*PW +: PW] = 8'hA0;
    srcPrio[5*PW +: PW]  = 8'h80;
    srcPrio[9*PW +: PW]  = 8'h40;
    srcPrio[12*PW +: PW] = 8'h20;
    srcPrio[20*PW +: PW] = 8'h90;
    srcAllCpu[9] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 run id cpu0", rid(0), 10'd1023);
    check("R1 run id cpu1", rid(1), 10'd1023);
    check("R1 run prio cpu0", rpr(0), 9'h100);
    check("R1 busy", busy, 0);
    check("R1 strobes", {ackValid, pendClrValid, pendSetValid}, 0);

    // R2 refusals
    doAck(0, 10'd1023, 10'd1023);
    check("R2 idle id unchanged", rid(0), 10'd1023);
    check("R2 no clear", pendClrValid, 0);

    // R3 R4 first acknowledge, per-CPU clear
    doAck(0, 10'd5, 10'd5);
    check("R3 run id", rid(0), 10'd5);
    check("R3 run prio", rpr(0), 9'h080);
    check("R4 clr id", pendClrId, 10'd5);
    check("R4 clr mask N:N", pendClrMask, 2'b01);

    doAck(0, 10'd20, 10'd1023);
    check("R2 lower priority refused", rid(0), 10'd5);
    doAck(0, 10'd5, 10'd1023);
    check("R2 equal priority refused", rid(0), 10'd5);
    doAck(0, 10'd40, 10'd1023);
    check("R2 out of range refused", rid(0), 10'd5);

    doAck(0, 10'd9, 10'd9);
    check("R4 clr mask 1:N", pendClrMask, 2'b11);
    doAck(0, 10'd12, 10'd12);
    check("R3 nested prio", rpr(0), 9'h020);

    // R11 other CPU independent
    doAck(1, 10'd20, 10'd20);
    check("R11 cpu1 run", rid(1), 10'd20);
    check("R11 cpu0 untouched", rid(0), 10'd12);

    // R9 R6 out-of-order completion of 5 with junk high bits, R10 drop mid-walk
    doEoi(0, 32'hABCD_FC05);
    check("R9 busy during walk", busy, 1);
    @(negedge clk);
    ackCpu = 1'b0; hiPendId[0 +: 10] = 10'd3; ackReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ackReq = 1'b0;
    check("R10 ack dropped while busy", ackValid, 0);
    waitIdle();
    check("R9 running kept", rid(0), 10'd12);

    // R7 pops through the spliced chain
    doEoi(0, 32'd12);
    check("R7 pop to 9", rid(0), 10'd9);
    check("R7 prio 9", rpr(0), 9'h040);
    doEoi(0, 32'd9);
    check("R9 splice skipped 5", rid(0), 10'd1023);
    check("R7 idle prio", rpr(0), 9'h100);

    // R5 completion with nothing running
    srcLevel[5] = 1'b1; srcEnable[5] = 1'b1; srcTarget[5*NC + 0] = 1'b1;
    doEoi(0, 32'd5);
    check("R5 no repend", pendSetValid, 0);
    check("R5 still idle", rid(0), 10'd1023);

    // R8 re-pend of held level source on cpu1
    srcLevel[20] = 1'b1; srcEnable[20] = 1'b1; srcTarget[20*NC + 1] = 1'b1;
    doEoi(1, 32'd20);
    check("R8 repend valid", pendSetValid, 1);
    check("R8 repend id", pendSetId, 10'd20);
    check("R8 repend mask", pendSetMask, 2'b10);
    check("R7 cpu1 idle", rid(1), 10'd1023);
    doAck(1, 10'd20, 10'd20);
    srcEdge[20] = 1'b1;
    doEoi(1, 32'd20);
    check("R8 edge source not repended", pendSetValid, 0);

    // R12 same-cycle ack and completion
    doAck(0, 10'd5, 10'd5);
    @(negedge clk);
    ackCpu = 1'b0; hiPendId[0 +: 10] = 10'd9; ackReq = 1'b1;
    eoiCpu = 1'b0; eoiData = 32'd5; eoiReq = 1'b1;
    expQ.push_back(10'd9);
    @(posedge clk);
    @(negedge clk);
    ackReq = 1'b0; eoiReq = 1'b0;
    check("R12 ack served", rid(0), 10'd9);
    doEoi(0, 32'd9);
    check("R12 completion was dropped", rid(0), 10'd5);

    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule